// File: doc/BRIEF.md
# Serial Lane Data Repacker

The repacker reshapes a byte stream so that one quad-capable serial shifter can carry both single-line and four-line flash payloads. In spread mode every byte headed for a single-line write is bit-reversed and each of its bits is given a 4-bit group of its own, in lane 0, so the shifter sends it on its data-in line. In gather mode a stream captured on all four lanes during a single-line read is collapsed back: only the lane that carries the flash's data-out line is kept. Swap mode reverses byte order inside 32-bit words for quad-line reads, including a short tail word. Pass mode forwards bytes unchanged.

A transfer begins with a one-cycle `start` pulse in idle. On that cycle the block takes the mode and the input byte count. Bytes then enter on a valid/ready port and leave on a second valid/ready port. Internally the block collects one group of up to four input bytes in a single word register and then drains it, so the input and output ports are never open in the same cycle. A byte moves on either port only in a cycle where both valid and ready are high. The producer may drop `in_valid` at any time. The consumer may hold `out_ready` low for any number of cycles; the offered byte then stays put and nothing is lost. A one-cycle `done` marks the end of the transfer.

Top module: `lane_repacker`

## Requirements
- R1: After reset `busy`, `in_ready`, `out_valid` and `done` are all low.
- R2: Mode code 0 (pass) emits each input byte unchanged, in order, one output byte per input byte.
- R3: Mode code 1 (spread) emits four bytes for each input byte b. In output byte j (j = 0..3), bit 0 is b[7-2j] and bit 4 is b[6-2j], and the other six bits are zero. This is the same as bit-reversing b and placing its bit i at bit 4i of a 32-bit little-endian group.
- R4: Mode code 2 (gather) treats the input as a bit stream. Stream bit n is bit n%8 of input byte n/8, with the first byte first. Output bit k (stream order, same numbering) is stream bit 4k+1. The output has ceil(len/4) bytes, and output bits beyond the input are zero.
- R5: Mode code 3 (swap) reverses the byte order inside each complete group of four input bytes.
- R6: In swap mode a trailing group of 1, 2 or 3 bytes is reversed within itself: one byte passes unchanged, two bytes trade places, and three bytes come out last-first.
- R7: While `out_valid` is high and `out_ready` is low, the next cycle keeps `out_valid` high with `out_data` unchanged, and no byte is dropped or repeated.
- R8: Mode and length are sampled only on the accepted `start` cycle. A change on `mode` or `len`, or a new `start` pulse, during a transfer has no effect on it.
- R9: `done` is high for one cycle, in the cycle after the final output handshake. A start with `len` = 0 takes no input, gives no output, and raises `done` in the cycle after `start`. No input byte is accepted beyond `len`.
- R10: `in_ready` and `out_valid` are never high together, and both stay low while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a transfer when idle |
| mode | input | 2 | 0 pass, 1 spread, 2 gather, 3 swap |
| len | input | LEN_W | Input byte count of the transfer |
| in_data | input | 8 | Input byte |
| in_valid | input | 1 | Input byte offered |
| in_ready | output | 1 | Block accepts an input byte |
| out_data | output | 8 | Output byte |
| out_valid | output | 1 | Output byte offered |
| out_ready | input | 1 | Consumer accepts the output byte |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |

## Verification
Properties checked every cycle cover four points: the stall rule on the output port, the two ports never being open together or while idle, no input accepted once the byte count is spent, and spread-mode bytes using only bit positions 0 and 4. The actual byte mappings cannot be shown by a cycle-local property. These are the reversed spread order, the 4k+1 lane pick with a zero-padded partial byte, and swap reversal of full and tail words. Whole transfers in the bench show them, with every output compared against a model built from the rules. The bench scenarios also show that mode and length are latched only at start, and where `done` lands for zero and non-zero lengths.

// File: rtl/lane_repack_pkg.sv
package lane_repack_pkg;

  localparam int unsigned GROUP_BYTES = 4;
  localparam int unsigned SLOT_W      = $clog2(GROUP_BYTES);
  localparam int unsigned CNT_W       = SLOT_W + 1;

  typedef enum logic [1:0] {
    RP_PASS   = 2'd0,
    RP_SPREAD = 2'd1,
    RP_GATHER = 2'd2,
    RP_SWAP   = 2'd3
  } rp_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FILL  = 2'd1,
    ST_DRAIN = 2'd2
  } rp_state_e;

  // Output byte j of a spread byte: lane-0 bits carry b MSB first.
  function automatic logic [7:0] spread_slice(input logic [7:0] b, input logic [SLOT_W-1:0] j);
    logic [7:0] r;
    int unsigned base;
    base = 2 * int'(j);
    r = '0;
    r[0] = b[7 - base];
    r[4] = b[6 - base];
    return r;
  endfunction

  // Keep bit 1 and bit 5 of every byte of a group: the data-out lane.
  function automatic logic [7:0] gather_word(input logic [GROUP_BYTES-1:0][7:0] w);
    logic [7:0] r;
    for (int m = 0; m < GROUP_BYTES; m++) begin
      r[2*m]     = w[m][1];
      r[2*m + 1] = w[m][5];
    end
    return r;
  endfunction

endpackage

// File: rtl/repack_seq.sv
module repack_seq
  import lane_repack_pkg::*;
#(
  parameter int unsigned LEN_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        mode_in,
  input  logic [LEN_W-1:0]  len_in,
  input  logic              in_valid,
  input  logic              out_ready,
  output logic              in_ready,
  output logic              out_valid,
  output logic              busy,
  output logic              done,
  output rp_mode_e          mode_q,
  output logic              take,
  output logic              word_clr,
  output logic [SLOT_W-1:0] slot,
  output logic [SLOT_W-1:0] drain_idx,
  output logic [CNT_W-1:0]  fill_n
);

  rp_state_e         state;
  logic [LEN_W-1:0]  rem;
  logic [CNT_W-1:0]  fill_cnt;
  logic [SLOT_W-1:0] drain_cnt;
  logic [SLOT_W-1:0] drain_last;
  logic              give;
  logic              group_end;
  logic              drain_end;

  assign in_ready  = (state == ST_FILL);
  assign out_valid = (state == ST_DRAIN);
  assign busy      = (state != ST_IDLE);
  assign take      = in_ready && in_valid;
  assign give      = out_valid && out_ready;

  // Pass and spread close a group after one byte; the others after a full word or the last byte.
  assign group_end = take && ((mode_q == RP_PASS) || (mode_q == RP_SPREAD) ||
                              (fill_cnt == CNT_W'(GROUP_BYTES - 1)) || (rem == LEN_W'(1)));

  always_comb begin
    case (mode_q)
      RP_SPREAD: drain_last = SLOT_W'(GROUP_BYTES - 1);
      RP_SWAP:   drain_last = SLOT_W'(fill_cnt - CNT_W'(1));
      default:   drain_last = '0;
    endcase
  end

  assign drain_end = give && (drain_cnt == drain_last);
  assign word_clr  = ((state == ST_IDLE) && start) || drain_end;
  assign slot      = fill_cnt[SLOT_W-1:0];
  assign drain_idx = drain_cnt;
  assign fill_n    = fill_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      rem       <= '0;
      fill_cnt  <= '0;
      drain_cnt <= '0;
      done      <= 1'b0;
      mode_q    <= RP_PASS;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            mode_q   <= rp_mode_e'(mode_in);
            rem      <= len_in;
            fill_cnt <= '0;
            if (len_in == '0) done  <= 1'b1;
            else              state <= ST_FILL;
          end
        end
        ST_FILL: begin
          if (take) begin
            rem      <= rem - LEN_W'(1);
            fill_cnt <= fill_cnt + CNT_W'(1);
            if (group_end) begin
              state     <= ST_DRAIN;
              drain_cnt <= '0;
            end
          end
        end
        ST_DRAIN: begin
          if (give) begin
            drain_cnt <= drain_cnt + SLOT_W'(1);
            if (drain_end) begin
              fill_cnt <= '0;
              if (rem == '0) begin
                state <= ST_IDLE;
                done  <= 1'b1;
              end else begin
                state <= ST_FILL;
              end
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_PORTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid)); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!in_ready && !out_valid)); // R10
  AST_NO_EXCESS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (rem != '0)); // R9
  AST_DONE_AT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!in_ready && !out_valid)); // R9

endmodule

// File: rtl/repack_word.sv
module repack_word
  import lane_repack_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_clr,
  input  logic              take,
  input  logic [SLOT_W-1:0] slot,
  input  logic [7:0]        in_data,
  input  rp_mode_e          mode_q,
  input  logic [SLOT_W-1:0] drain_idx,
  input  logic [CNT_W-1:0]  fill_n,
  output logic [7:0]        out_data
);

  logic [GROUP_BYTES-1:0][7:0] word_q;
  logic [SLOT_W-1:0]           swap_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        word_q       <= '0;
    else if (word_clr) word_q       <= '0;
    else if (take)     word_q[slot] <= in_data;
  end

  assign swap_idx = SLOT_W'(fill_n - CNT_W'(1) - CNT_W'(drain_idx));

  always_comb begin
    case (mode_q)
      RP_SPREAD: out_data = spread_slice(word_q[0], drain_idx);
      RP_GATHER: out_data = gather_word(word_q);
      RP_SWAP:   out_data = word_q[swap_idx];
      default:   out_data = word_q[0];
    endcase
  end

endmodule

// File: rtl/lane_repacker.sv
module lane_repacker
  import lane_repack_pkg::*;
#(
  parameter int unsigned LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       mode,
  input  logic [LEN_W-1:0] len,
  input  logic [7:0]       in_data,
  input  logic             in_valid,
  output logic             in_ready,
  output logic [7:0]       out_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             busy,
  output logic             done
);

  rp_mode_e          mode_q;
  logic              take;
  logic              word_clr;
  logic [SLOT_W-1:0] slot;
  logic [SLOT_W-1:0] drain_idx;
  logic [CNT_W-1:0]  fill_n;

  repack_seq #(.LEN_W(LEN_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .mode_in   (mode),
    .len_in    (len),
    .in_valid  (in_valid),
    .out_ready (out_ready),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .busy      (busy),
    .done      (done),
    .mode_q    (mode_q),
    .take      (take),
    .word_clr  (word_clr),
    .slot      (slot),
    .drain_idx (drain_idx),
    .fill_n    (fill_n)
  );

  repack_word u_word (
    .clk       (clk),
    .rst_n     (rst_n),
    .word_clr  (word_clr),
    .take      (take),
    .slot      (slot),
    .in_data   (in_data),
    .mode_q    (mode_q),
    .drain_idx (drain_idx),
    .fill_n    (fill_n),
    .out_data  (out_data)
  );

  AST_STALL_KEEPS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid); // R7
  AST_STALL_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> $stable(out_data)); // R7
  AST_SPREAD_LANE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && mode_q == RP_SPREAD) |-> ((out_data & 8'hEE) == 8'h00)); // R3

endmodule

// File: tb/lane_repacker_bench.sv
module lane_repacker_bench;

  localparam int CLK_PERIOD = 10;
  localparam int LEN_W      = 16;
  localparam int WATCHDOG   = 100000;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [1:0]       mode = 2'd0;
  logic [LEN_W-1:0] len = '0;
  logic [7:0]       in_data = '0;
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic [7:0]       out_data;
  logic             out_valid;
  logic             out_ready = 1'b0;
  logic             busy;
  logic             done;

  int n_checks = 0;
  int n_fail   = 0;
  int done_cnt = 0;
  int cycles   = 0;
  logic [7:0]  exp_q [$];
  string       tag_q [$];
  logic [15:0] lfsr = 16'hACE1;
  logic [7:0]  seed = 8'h3C;
  logic        prev_stall = 1'b0;
  logic [7:0]  prev_data  = '0;
  bit          monitor_on = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lane_repacker #(.LEN_W(LEN_W)) u_lane_repacker (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .len(len),
    .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
    .busy(busy), .done(done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  // Monitor: the out_ready choice and the handshake it implies for the next edge.
  always @(negedge clk) begin
    if (monitor_on) begin
      if (prev_stall) begin
        check(out_valid === 1'b1 && out_data === prev_data, "R7", {out_valid, out_data},
              {1'b1, prev_data});
      end
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready = (lfsr[1:0] != 2'b00);
      if (in_ready && out_valid) check(1'b0, "R10", 1, 0);
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R9 extra output", out_data, 0);
        end else begin
          logic [7:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(out_data === e, t, out_data, e);
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
      if (done) begin
        check(exp_q.size() == 0, "R9 done before all outputs", exp_q.size(), 0);
        done_cnt++;
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      check(1'b0, "watchdog", cycles, WATCHDOG);
      finish_run();
    end
  end

  task automatic push_exp(input logic [7:0] v, input string t);
    exp_q.push_back(v);
    tag_q.push_back(t);
  endtask

  // One transfer: expected bytes from the requirement rules, then drive inputs.
  task automatic run_xfer(input logic [1:0] m, input int n, input bit disturb, input string force_tag);
    logic [7:0] src [$];
    int idx;
    int gap;
    int done_before;
    for (int i = 0; i < n; i++) begin
      seed = seed * 8'd29 + 8'd71;
      src.push_back(seed);
    end
    case (m)
      2'd0: for (int i = 0; i < n; i++) push_exp(src[i], force_tag != "" ? force_tag : "R2");
      2'd1: begin
        for (int i = 0; i < n; i++) begin
          logic [7:0] r;
          for (int b = 0; b < 8; b++) r[b] = src[i][7-b];
          for (int j = 0; j < 4; j++) begin
            logic [7:0] o;
            o = 8'h00;
            o[0] = r[2*j];
            o[4] = r[2*j+1];
            push_exp(o, "R3");
          end
        end
      end
      2'd2: begin
        int nout;
        nout = (n + 3) / 4;
        for (int q = 0; q < nout; q++) begin
          logic [7:0] o;
          for (int b = 0; b < 8; b++) begin
            int s;
            s = 4 * (8*q + b) + 1;
            o[b] = (s/8 < n) ? src[s/8][s%8] : 1'b0;
          end
          push_exp(o, "R4");
        end
      end
      default: begin
        for (int g = 0; g < n; g += 4) begin
          int cnt;
          cnt = (n - g < 4) ? n - g : 4;
          for (int j = 0; j < cnt; j++) push_exp(src[g + cnt - 1 - j], cnt == 4 ? "R5" : "R6");
        end
      end
    endcase
    done_before = done_cnt;
    @(negedge clk);
    start = 1'b1; mode = m; len = LEN_W'(n);
    @(negedge clk);
    start = 1'b0; mode = ~m; len = LEN_W'(n + 7); // R8: pins move after start
    if (n == 0) begin
      check(done === 1'b1 && busy === 1'b0 && in_ready === 1'b0, "R9 zero length",
            {done, busy, in_ready}, 3'b100);
    end
    idx = 0;
    gap = 0;
    while (idx < n) begin
      gap++;
      in_valid = (gap % 3 != 2);
      in_data  = src[idx];
      start    = disturb && (idx == 1); // R8: ignored restart
      if (in_valid && in_ready) idx++;
      @(negedge clk);
    end
    in_valid = 1'b0;
    start    = 1'b0;
    while (done_cnt == done_before) @(negedge clk);
    @(negedge clk);
    check(busy === 1'b0 && in_ready === 1'b0 && out_valid === 1'b0, "R10 idle after done",
          {busy, in_ready, out_valid}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(busy === 1'b0 && in_ready === 1'b0 && out_valid === 1'b0 && done === 1'b0, "R1",
          {busy, in_ready, out_valid, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy === 1'b0 && done === 1'b0, "R1 after release", {busy, done}, 0);
    monitor_on = 1'b1;
    run_xfer(2'd0, 5, 1'b0, "");     // R2
    run_xfer(2'd1, 3, 1'b0, "");     // R3
    run_xfer(2'd2, 8, 1'b0, "");     // R4 whole bytes
    run_xfer(2'd2, 6, 1'b0, "");     // R4 padded tail
    run_xfer(2'd2, 1, 1'b0, "");     // R4 single input byte
    run_xfer(2'd3, 8, 1'b0, "");     // R5
    run_xfer(2'd3, 5, 1'b0, "");     // R6 one-byte tail
    run_xfer(2'd3, 6, 1'b0, "");     // R6 two-byte tail
    run_xfer(2'd3, 7, 1'b0, "");     // R6 three-byte tail
    run_xfer(2'd3, 3, 1'b0, "");     // R6 tail only
    run_xfer(2'd0, 0, 1'b0, "");     // R9 zero length
    run_xfer(2'd0, 6, 1'b1, "R8");   // R8 restart and pin changes ignored
    run_xfer(2'd1, 2, 1'b1, "");     // R8 in spread mode
    check(exp_q.size() == 0, "R7 no byte lost", exp_q.size(), 0);
    finish_run();
  end

endmodule